// File: doc/BRIEF.md
# Multi-Page Entry Update Sequencer

This block takes one command that rewrites a run of consecutive entries in an address translation table. It issues one entry write per page on the table's maintenance port and steps the bus address by one page each time. In fill mode every page gets the same 64-bit value from the command. In list mode the value for each page comes from an array of 64-bit words in memory. The block reads these words one at a time over a simple request/response read port and treats each word as big-endian.

Before any access, the command is checked. An unknown table identifier is refused. An empty run is refused. A list-mode run longer than the list limit, or with a list base that is not on a 4 KiB boundary, is refused. A fill-mode run longer than the table is refused.

When the run ends, the block raises a one-cycle done pulse. With it come a status code and the index of the last element it handled. The first write that reports an error ends the run at once, and its code becomes the status. The table storage and the arbitration of the read bus are outside this block.

Top module: `page_entry_update_seq`

## Requirements
- R1: A command whose table identifier lies outside [ID_BASE, ID_BASE+NUM_TABLES) finishes with status 1 (parameter error) and last index 0, and makes no read and no write.
- R2: In list mode, a page count above MAX_LIST (512), or a list base with any of its low 12 address bits set, finishes with status 1 and makes no access. A count of exactly 512 on an aligned base is accepted.
- R3: In fill mode, a page count above TABLE_ENTRIES (1024) finishes with status 1 and makes no write. A count equal to TABLE_ENTRIES is accepted, even though it is above the list limit.
- R4: A page count of zero finishes with status 1 in both modes, with no read and no write.
- R5: The address of write i is the command bus address with its low PAGE_SHIFT bits cleared, plus i times 2^PAGE_SHIFT. An accepted run of N pages with no error makes exactly N writes, every write address page aligned.
- R6: In fill mode, every write carries the command fill value, and no memory read is issued.
- R7: In list mode, element i is read at list base + 8*i. The byte at the lowest address arrives in rd_rsp_data[7:0] and becomes the most significant byte of the written entry, so entry = byte-reversed rd_rsp_data.
- R8: Only one read is outstanding at a time. While rd_req_valid is high and rd_req_ready is low, the request and its address stay unchanged. Every read address is 8-byte aligned.
- R9: The first write acknowledged with a nonzero wr_status ends the run: no further read or write follows, and that code becomes the status. Otherwise the status is 0.
- R10: last_idx is N-1 after N successful writes. It is k-1 when element k>0 fails, 0 when element 0 fails, and 0 on any parameter error.
- R11: done is a single-cycle pulse. status and last_idx are valid while done is high and keep their values until the next command finishes.
- R12: cmd_ready is high only while the block is idle. A cmd_valid presented while cmd_ready is low is ignored: it causes no write and no extra done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle; command taken when both are high |
| cmd_list_mode | input | 1 | 1 = list mode, 0 = fill mode |
| cmd_table_id | input | ID_W | Target table identifier |
| cmd_bus_addr | input | ADDR_W | Starting bus address (page offset ignored) |
| cmd_list_addr | input | ADDR_W | Base of the entry list (list mode) |
| cmd_fill_value | input | 64 | Entry value (fill mode) |
| cmd_npages | input | CNT_W | Number of pages |
| wr_req | output | 1 | One-cycle entry write request |
| wr_table | output | ID_W | Table identifier of the write |
| wr_addr | output | ADDR_W | Page-aligned bus address being updated |
| wr_data | output | 64 | New entry value |
| wr_ack | input | 1 | Write response, at least one cycle after wr_req |
| wr_status | input | 2 | Write result, 0 = success |
| rd_req_valid | output | 1 | List word read request |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | ADDR_W | Read address |
| rd_rsp_valid | input | 1 | Read data present |
| rd_rsp_data | input | 64 | Read data, lowest-address byte in bits 7:0 |
| done | output | 1 | Command finished (one cycle) |
| status | output | 2 | 0 ok, 1 parameter error, else the failing write code |
| last_idx | output | CNT_W | Last processed element |

## Verification
The bench probes the limits on each side: 512 against 513 list entries, 1024 against 1025 fill pages, a list base that is only 8-byte aligned, an empty run, and identifiers just outside the valid range. A design that swapped the two limits would refuse the 1024-page fill. A design that skipped the zero check would report success. Error injection at element 0 and at element 2 checks both the early stop and the two branches of the index rule. An off-by-one design would report the failing element, or make a write after the failure. List runs compare every read address and every byte-reversed entry, which exposes a wrong stride or the wrong byte order. A command presented while the block is busy must leave the number of writes and done pulses unchanged.

// File: rtl/pe_upd_pkg.sv
package pe_upd_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_CHECK,
      S_FETCH,
      S_WRITE,
      S_WAIT_ACK,
      S_DONE
   } seq_state_e;

   typedef enum logic [1:0] {
      F_IDLE,
      F_REQ,
      F_RSP
   } fetch_state_e;

   localparam logic [1:0] ST_OK    = 2'd0;
   localparam logic [1:0] ST_PARAM = 2'd1;

endpackage

// File: rtl/pe_upd_check.sv
module pe_upd_check #(
   parameter int unsigned ADDR_W           = 48,
   parameter int unsigned CNT_W            = 16,
   parameter int unsigned ID_W             = 32,
   parameter int unsigned ID_BASE          = 32'h100,
   parameter int unsigned NUM_TABLES       = 2,
   parameter int unsigned TABLE_ENTRIES    = 1024,
   parameter int unsigned MAX_LIST         = 512,
   parameter int unsigned LIST_ALIGN_SHIFT = 12
) (
   input  logic              list_mode,
   input  logic [ID_W-1:0]   table_id,
   input  logic [ADDR_W-1:0] list_addr,
   input  logic [CNT_W-1:0]  npages,
   output logic              reject
);

   localparam logic [CNT_W-1:0] LIST_LIMIT = CNT_W'(MAX_LIST);
   localparam logic [CNT_W-1:0] FILL_LIMIT = CNT_W'(TABLE_ENTRIES);
   localparam logic [ID_W-1:0]  ID_LO      = ID_W'(ID_BASE);
   localparam logic [ID_W-1:0]  ID_SPAN    = ID_W'(NUM_TABLES);

   logic id_known;
   logic list_bad;
   logic fill_bad;

   generate
      if (NUM_TABLES == 1) begin : g_single_id
         assign id_known = (table_id == ID_LO);
      end else begin : g_id_range
         logic [ID_W-1:0] id_ofs;
         assign id_ofs   = table_id - ID_LO;
         assign id_known = (table_id >= ID_LO) && (id_ofs < ID_SPAN);
      end
   endgenerate

   assign list_bad = (npages > LIST_LIMIT) ||
                     (list_addr[LIST_ALIGN_SHIFT-1:0] != '0);
   assign fill_bad = (npages > FILL_LIMIT);

   always_comb begin
      reject = !id_known || (npages == '0);
      if (list_mode) reject = reject || list_bad;
      else           reject = reject || fill_bad;
   end

endmodule

// File: rtl/pe_upd_fetch.sv
module pe_upd_fetch
   import pe_upd_pkg::*;
#(
   parameter int unsigned ADDR_W = 48
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [ADDR_W-1:0] addr_in,
   output logic              idle,
   output logic              got,
   output logic [63:0]       entry,
   output logic              rd_req_valid,
   input  logic              rd_req_ready,
   output logic [ADDR_W-1:0] rd_req_addr,
   input  logic              rd_rsp_valid,
   input  logic [63:0]       rd_rsp_data
);

   localparam int unsigned NBYTES = 8;

   fetch_state_e      fst;
   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fst    <= F_IDLE;
         addr_q <= '0;
      end else begin
         case (fst)
            F_IDLE: if (go) begin
               addr_q <= addr_in;
               fst    <= F_REQ;
            end
            F_REQ:  if (rd_req_ready) fst <= F_RSP;
            F_RSP:  if (rd_rsp_valid) fst <= F_IDLE;
            default: fst <= F_IDLE;
         endcase
      end
   end

   assign idle         = (fst == F_IDLE);
   assign rd_req_valid = (fst == F_REQ);
   assign rd_req_addr  = addr_q;
   assign got          = (fst == F_RSP) && rd_rsp_valid;

   // lowest-address byte (bits 7:0) is the most significant byte of the entry
   generate
      for (genvar b = 0; b < NBYTES; b++) begin : g_swap
         assign entry[63-8*b -: 8] = rd_rsp_data[8*b +: 8];
      end
   endgenerate

   // R8: request held steady until accepted
   p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr))
      else $error("read request dropped or moved before acceptance");

   // R8: no new request while a response is awaited
   p_one_outstanding_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_valid && rd_req_ready |=> !rd_req_valid)
      else $error("second read issued while one is outstanding");

   // R7: list words are 8-byte aligned
   p_word_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_valid |-> rd_req_addr[2:0] == 3'b000)
      else $error("misaligned list read");

endmodule

// File: rtl/page_entry_update_seq.sv
module page_entry_update_seq
   import pe_upd_pkg::*;
#(
   parameter int unsigned ADDR_W           = 48,
   parameter int unsigned CNT_W            = 16,
   parameter int unsigned ID_W             = 32,
   parameter int unsigned ID_BASE          = 32'h100,
   parameter int unsigned NUM_TABLES       = 2,
   parameter int unsigned TABLE_ENTRIES    = 1024,
   parameter int unsigned MAX_LIST         = 512,
   parameter int unsigned PAGE_SHIFT       = 12,
   parameter int unsigned LIST_ALIGN_SHIFT = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic              cmd_list_mode,
   input  logic [ID_W-1:0]   cmd_table_id,
   input  logic [ADDR_W-1:0] cmd_bus_addr,
   input  logic [ADDR_W-1:0] cmd_list_addr,
   input  logic [63:0]       cmd_fill_value,
   input  logic [CNT_W-1:0]  cmd_npages,
   output logic              wr_req,
   output logic [ID_W-1:0]   wr_table,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [63:0]       wr_data,
   input  logic              wr_ack,
   input  logic [1:0]        wr_status,
   output logic              rd_req_valid,
   input  logic              rd_req_ready,
   output logic [ADDR_W-1:0] rd_req_addr,
   input  logic              rd_rsp_valid,
   input  logic [63:0]       rd_rsp_data,
   output logic              done,
   output logic [1:0]        status,
   output logic [CNT_W-1:0]  last_idx
);

   localparam logic [ADDR_W-1:0] PAGE_STEP = {{(ADDR_W-1){1'b0}}, 1'b1} << PAGE_SHIFT;
   localparam logic [ADDR_W-1:0] PAGE_OFS  = PAGE_STEP - 1'b1;
   localparam int unsigned       WORD_SHIFT = 3;

   initial begin
      assert (PAGE_SHIFT >= WORD_SHIFT && PAGE_SHIFT < ADDR_W)
         else $error("PAGE_SHIFT out of range");
      assert (LIST_ALIGN_SHIFT >= WORD_SHIFT && LIST_ALIGN_SHIFT < ADDR_W)
         else $error("LIST_ALIGN_SHIFT out of range");
      assert (TABLE_ENTRIES < (1 << CNT_W) && MAX_LIST < (1 << CNT_W))
         else $error("CNT_W too narrow for the limits");
      assert (NUM_TABLES >= 1) else $error("NUM_TABLES must be positive");
   end

   seq_state_e        state;
   logic              list_q;
   logic [ID_W-1:0]   id_q;
   logic [ADDR_W-1:0] page_q;
   logic [ADDR_W-1:0] lbase_q;
   logic [63:0]       fill_q;
   logic [63:0]       data_q;
   logic [CNT_W-1:0]  npages_q;
   logic [CNT_W-1:0]  elem_q;
   logic [1:0]        status_q;
   logic [CNT_W-1:0]  idx_q;

   logic              reject;
   logic              f_go;
   logic              f_idle;
   logic              f_got;
   logic [63:0]       f_entry;
   logic [ADDR_W-1:0] f_addr;
   logic              last_elem;

   pe_upd_check #(
      .ADDR_W(ADDR_W), .CNT_W(CNT_W), .ID_W(ID_W), .ID_BASE(ID_BASE),
      .NUM_TABLES(NUM_TABLES), .TABLE_ENTRIES(TABLE_ENTRIES),
      .MAX_LIST(MAX_LIST), .LIST_ALIGN_SHIFT(LIST_ALIGN_SHIFT)
   ) u_check (
      .list_mode (list_q),
      .table_id  (id_q),
      .list_addr (lbase_q),
      .npages    (npages_q),
      .reject    (reject)
   );

   assign f_addr = lbase_q + (ADDR_W'(elem_q) << WORD_SHIFT);
   assign f_go   = (state == S_FETCH) && f_idle;

   pe_upd_fetch #(.ADDR_W(ADDR_W)) u_fetch (
      .clk          (clk),
      .rst_n        (rst_n),
      .go           (f_go),
      .addr_in      (f_addr),
      .idle         (f_idle),
      .got          (f_got),
      .entry        (f_entry),
      .rd_req_valid (rd_req_valid),
      .rd_req_ready (rd_req_ready),
      .rd_req_addr  (rd_req_addr),
      .rd_rsp_valid (rd_rsp_valid),
      .rd_rsp_data  (rd_rsp_data)
   );

   assign last_elem = (elem_q == npages_q - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= S_IDLE;
         list_q   <= 1'b0;
         id_q     <= '0;
         page_q   <= '0;
         lbase_q  <= '0;
         fill_q   <= '0;
         data_q   <= '0;
         npages_q <= '0;
         elem_q   <= '0;
         status_q <= ST_OK;
         idx_q    <= '0;
      end else begin
         case (state)
            S_IDLE: if (cmd_valid) begin
               list_q   <= cmd_list_mode;
               id_q     <= cmd_table_id;
               page_q   <= cmd_bus_addr & ~PAGE_OFS;
               lbase_q  <= cmd_list_addr;
               fill_q   <= cmd_fill_value;
               npages_q <= cmd_npages;
               elem_q   <= '0;
               state    <= S_CHECK;
            end
            S_CHECK: begin
               if (reject) begin
                  status_q <= ST_PARAM;
                  idx_q    <= '0;
                  state    <= S_DONE;
               end else begin
                  state <= list_q ? S_FETCH : S_WRITE;
               end
            end
            S_FETCH: if (f_got) begin
               data_q <= f_entry;
               state  <= S_WRITE;
            end
            S_WRITE: state <= S_WAIT_ACK;
            S_WAIT_ACK: if (wr_ack) begin
               if (wr_status != ST_OK) begin
                  status_q <= wr_status;
                  idx_q    <= (elem_q == '0) ? '0 : elem_q - 1'b1;
                  state    <= S_DONE;
               end else if (last_elem) begin
                  status_q <= ST_OK;
                  idx_q    <= elem_q;
                  state    <= S_DONE;
               end else begin
                  elem_q <= elem_q + 1'b1;
                  page_q <= page_q + PAGE_STEP;
                  state  <= list_q ? S_FETCH : S_WRITE;
               end
            end
            S_DONE: state <= S_IDLE;
            default: state <= S_IDLE;
         endcase
      end
   end

   assign cmd_ready = (state == S_IDLE);
   assign wr_req    = (state == S_WRITE);
   assign wr_table  = id_q;
   assign wr_addr   = page_q;
   assign wr_data   = list_q ? data_q : fill_q;
   assign done      = (state == S_DONE);
   assign status    = status_q;
   assign last_idx  = idx_q;

   // R5: every write targets a page boundary
   p_wr_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req |-> wr_addr[PAGE_SHIFT-1:0] == '0)
      else $error("write address not page aligned");

   // R6: fill mode never reads memory
   p_fill_no_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_valid |-> list_q)
      else $error("read issued in fill mode");

   // R9: a failing acknowledge ends the run with its code
   p_stop_on_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_WAIT_ACK) && wr_ack && (wr_status != ST_OK)
      |=> done && (status == $past(wr_status)))
      else $error("run continued after a failing write");

   // R10: parameter errors report index 0
   p_param_idx_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done && (status == ST_PARAM) && !$past(wr_ack) |-> last_idx == '0)
      else $error("parameter error with nonzero index");

   // R11: done lasts one cycle
   p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done)
      else $error("done longer than one cycle");

   // R12: no command accepted while busy
   p_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req |-> !cmd_ready)
      else $error("ready while writing");

endmodule

// File: tb/tb_page_entry_update_seq.sv
`timescale 1ns/1ps
module tb_page_entry_update_seq;

   localparam int ADDR_W = 48;
   localparam int CNT_W  = 16;
   localparam int ID_W   = 32;
   localparam int MAXREC = 1100;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cmd_valid = 1'b0;
   logic              cmd_ready;
   logic              cmd_list_mode = 1'b0;
   logic [ID_W-1:0]   cmd_table_id = '0;
   logic [ADDR_W-1:0] cmd_bus_addr = '0;
   logic [ADDR_W-1:0] cmd_list_addr = '0;
   logic [63:0]       cmd_fill_value = '0;
   logic [CNT_W-1:0]  cmd_npages = '0;
   logic              wr_req;
   logic [ID_W-1:0]   wr_table;
   logic [ADDR_W-1:0] wr_addr;
   logic [63:0]       wr_data;
   logic              wr_ack = 1'b0;
   logic [1:0]        wr_status = 2'd0;
   logic              rd_req_valid;
   logic              rd_req_ready = 1'b0;
   logic [ADDR_W-1:0] rd_req_addr;
   logic              rd_rsp_valid = 1'b0;
   logic [63:0]       rd_rsp_data = '0;
   logic              done;
   logic [1:0]        status;
   logic [CNT_W-1:0]  last_idx;

   always #2.5 clk = ~clk;

   page_entry_update_seq dut (.*);

   int n_checks = 0;
   int n_fail   = 0;

   // recorded traffic
   logic [ADDR_W-1:0] w_addr [0:MAXREC-1];
   logic [63:0]       w_data [0:MAXREC-1];
   logic [ADDR_W-1:0] r_addr [0:MAXREC-1];
   int wn = 0;
   int rn = 0;
   int fail_at = -1;
   logic [1:0] fail_code = 2'd0;

   function automatic logic [63:0] mem_word(input logic [ADDR_W-1:0] a);
      return {a[31:0] ^ 32'hA5C3_0F1E, ~a[31:0]};
   endfunction

   function automatic logic [63:0] bswap(input logic [63:0] d);
      logic [63:0] o;
      for (int b = 0; b < 8; b++) o[63-8*b -: 8] = d[8*b +: 8];
      return o;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // write responder: ack one cycle after the request
   initial begin
      bit pend = 0;
      logic [1:0] pcode = 2'd0;
      forever begin
         @(negedge clk);
         wr_ack = 1'b0;
         wr_status = 2'd0;
         if (pend) begin
            wr_ack = 1'b1;
            wr_status = pcode;
            pend = 0;
         end else if (wr_req) begin
            if (wn < MAXREC) begin
               w_addr[wn] = wr_addr;
               w_data[wn] = wr_data;
            end
            pcode = (wn == fail_at) ? fail_code : 2'd0;
            wn++;
            pend = 1;
         end
      end
   end

   // read responder
   initial begin
      bit rph = 0;
      logic [ADDR_W-1:0] ra = '0;
      forever begin
         @(negedge clk);
         rd_rsp_valid = 1'b0;
         if (rph) begin
            rd_req_ready = 1'b0;
            rd_rsp_valid = 1'b1;
            rd_rsp_data  = mem_word(ra);
            rph = 0;
         end else if (rd_req_valid) begin
            ra = rd_req_addr;
            if (rn < MAXREC) r_addr[rn] = ra;
            rn++;
            rd_req_ready = 1'b1;
            rph = 1;
         end
      end
   end

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

   logic [1:0]       got_st;
   logic [CNT_W-1:0] got_idx;

   task automatic run_cmd(input bit lm, input logic [ID_W-1:0] id,
                          input logic [ADDR_W-1:0] ba, input logic [ADDR_W-1:0] la,
                          input logic [63:0] fv, input logic [CNT_W-1:0] n,
                          input int f_at, input logic [1:0] f_code);
      wn = 0; rn = 0; fail_at = f_at; fail_code = f_code;
      @(negedge clk);
      cmd_list_mode = lm; cmd_table_id = id; cmd_bus_addr = ba;
      cmd_list_addr = la; cmd_fill_value = fv; cmd_npages = n;
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      while (!done) @(negedge clk);
      got_st = status;
      got_idx = last_idx;
      repeat (4) @(negedge clk);
   endtask

   task automatic t_reset;
      chk(cmd_ready == 1'b1, "R12 reset ready", 64'(cmd_ready), 64'd1);
      chk(!done && !wr_req && !rd_req_valid, "R11 reset outputs idle",
          {61'd0, done, wr_req, rd_req_valid}, 64'd0);
      chk(status == 2'd0 && last_idx == '0, "R10 reset status/index",
          {46'd0, status, last_idx}, 64'd0);
   endtask

   task automatic t_fill_ok;
      run_cmd(0, 32'h100, 48'h0000_1234_5678, 48'h0, 64'hDEAD_BEEF_0000_0003, 16'd5, -1, 2'd0);
      chk(wn == 5, "R5 fill write count", 64'(wn), 64'd5);
      for (int i = 0; i < 5; i++) begin
         chk(w_addr[i] == 48'h1234_5000 + 48'(i) * 48'h1000, "R5 fill write address",
             64'(w_addr[i]), 64'(48'h1234_5000 + 48'(i) * 48'h1000));
         chk(w_data[i] == 64'hDEAD_BEEF_0000_0003, "R6 fill write data",
             w_data[i], 64'hDEAD_BEEF_0000_0003);
      end
      chk(rn == 0, "R6 fill mode makes no read", 64'(rn), 64'd0);
      chk(got_st == 2'd0, "R9 fill status ok", 64'(got_st), 64'd0);
      chk(got_idx == 16'd4, "R10 fill last index", 64'(got_idx), 64'd4);
   endtask

   task automatic t_list_ok;
      run_cmd(1, 32'h101, 48'h0040_0000_0FFF, 48'h8000, 64'h0, 16'd4, -1, 2'd0);
      chk(rn == 4 && wn == 4, "R7 list read/write counts", 64'(rn * 100 + wn), 64'd404);
      for (int i = 0; i < 4; i++) begin
         logic [ADDR_W-1:0] ea;
         ea = 48'h8000 + 48'(8 * i);
         chk(r_addr[i] == ea, "R7 list read address", 64'(r_addr[i]), 64'(ea));
         chk(w_data[i] == bswap(mem_word(ea)), "R7 list entry byte order",
             w_data[i], bswap(mem_word(ea)));
         chk(w_addr[i] == 48'h0040_0000_0000 + 48'(i) * 48'h1000, "R5 list write address",
             64'(w_addr[i]), 64'(48'h0040_0000_0000 + 48'(i) * 48'h1000));
      end
      chk(got_st == 2'd0 && got_idx == 16'd3, "R10 list success index",
          64'(got_idx), 64'd3);
   endtask

   task automatic t_fill_err_mid;
      run_cmd(0, 32'h100, 48'h2000, 48'h0, 64'h55, 16'd6, 2, 2'd2);
      chk(wn == 3, "R9 stop after failing write", 64'(wn), 64'd3);
      chk(got_st == 2'd2, "R9 failing code as status", 64'(got_st), 64'd2);
      chk(got_idx == 16'd1, "R10 index is k-1 on failure", 64'(got_idx), 64'd1);
   endtask

   task automatic t_list_err_first;
      run_cmd(1, 32'h100, 48'h2000, 48'h3000, 64'h0, 16'd6, 0, 2'd3);
      chk(wn == 1 && rn == 1, "R9 list stop at element 0", 64'(rn * 100 + wn), 64'd101);
      chk(got_st == 2'd3, "R9 list failing code", 64'(got_st), 64'd3);
      chk(got_idx == 16'd0, "R10 index 0 when element 0 fails", 64'(got_idx), 64'd0);
   endtask

   task automatic t_bad_id;
      run_cmd(0, 32'h102, 48'h2000, 48'h0, 64'h1, 16'd2, -1, 2'd0);
      chk(got_st == 2'd1 && wn == 0, "R1 id above range rejected", 64'(got_st), 64'd1);
      run_cmd(1, 32'hFF, 48'h2000, 48'h4000, 64'h1, 16'd2, -1, 2'd0);
      chk(got_st == 2'd1 && wn == 0 && rn == 0, "R1 id below range rejected",
          64'(got_st), 64'd1);
      chk(got_idx == 16'd0, "R10 parameter error index", 64'(got_idx), 64'd0);
   endtask

   task automatic t_list_limits;
      run_cmd(1, 32'h100, 48'h0, 48'h10000, 64'h0, 16'd513, -1, 2'd0);
      chk(got_st == 2'd1 && wn == 0 && rn == 0, "R2 list count 513 rejected",
          64'(got_st), 64'd1);
      run_cmd(1, 32'h100, 48'h0, 48'h8008, 64'h0, 16'd2, -1, 2'd0);
      chk(got_st == 2'd1 && rn == 0, "R2 list base 8-byte aligned rejected",
          64'(got_st), 64'd1);
      run_cmd(1, 32'h100, 48'h0, 48'h8800, 64'h0, 16'd2, -1, 2'd0);
      chk(got_st == 2'd1 && rn == 0, "R2 list base half-page rejected", 64'(got_st), 64'd1);
      run_cmd(1, 32'h101, 48'h0, 48'h10000, 64'h0, 16'd512, -1, 2'd0);
      chk(got_st == 2'd0 && wn == 512, "R2 list count 512 accepted", 64'(wn), 64'd512);
      chk(got_idx == 16'd511, "R10 index after 512 elements", 64'(got_idx), 64'd511);
      chk(r_addr[511] == 48'h10000 + 48'd4088, "R7 last list read address",
          64'(r_addr[511]), 64'(48'h10000 + 48'd4088));
   endtask

   task automatic t_fill_limits;
      run_cmd(0, 32'h100, 48'h0, 48'h0, 64'h7, 16'd1025, -1, 2'd0);
      chk(got_st == 2'd1 && wn == 0, "R3 fill count 1025 rejected", 64'(got_st), 64'd1);
      run_cmd(0, 32'h100, 48'h0, 48'h0, 64'h7, 16'd1024, -1, 2'd0);
      chk(got_st == 2'd0 && wn == 1024, "R3 fill count 1024 accepted", 64'(wn), 64'd1024);
      chk(w_addr[1023] == 48'h3FF000, "R5 last fill address", 64'(w_addr[1023]),
          64'h3FF000);
   endtask

   task automatic t_zero;
      run_cmd(0, 32'h100, 48'h0, 48'h0, 64'h7, 16'd0, -1, 2'd0);
      chk(got_st == 2'd1 && wn == 0, "R4 zero pages fill", 64'(got_st), 64'd1);
      run_cmd(1, 32'h100, 48'h0, 48'h1000, 64'h7, 16'd0, -1, 2'd0);
      chk(got_st == 2'd1 && wn == 0 && rn == 0, "R4 zero pages list", 64'(got_st), 64'd1);
   endtask

   task automatic t_busy_ignore;
      int dones;
      wn = 0; rn = 0; fail_at = -1; dones = 0;
      @(negedge clk);
      cmd_list_mode = 0; cmd_table_id = 32'h100; cmd_bus_addr = 48'h5000;
      cmd_fill_value = 64'hAB; cmd_npages = 16'd3; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      @(negedge clk);
      chk(cmd_ready == 1'b0, "R12 not ready while busy", 64'(cmd_ready), 64'd0);
      cmd_table_id = 32'h101; cmd_bus_addr = 48'h9000; cmd_npages = 16'd7;
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      for (int c = 0; c < 60; c++) begin
         @(negedge clk);
         if (done) begin
            dones++;
            if (dones == 1) begin
               got_st = status;
               got_idx = last_idx;
            end
         end
      end
      chk(wn == 3, "R12 busy command caused no writes", 64'(wn), 64'd3);
      chk(dones == 1, "R11 single done pulse", 64'(dones), 64'd1);
      chk(status == 2'd0 && last_idx == 16'd2, "R11 status held after done",
          64'(last_idx), 64'd2);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_fill_ok();
      t_list_ok();
      t_fill_err_mid();
      t_list_err_first();
      t_bad_id();
      t_list_limits();
      t_fill_limits();
      t_zero();
      t_busy_ignore();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

endmodule